// File: doc/BRIEF.md
# Random Early Drop Admission Unit

This block sits beside a packet queue and rules on every arriving packet at the moment it arrives. It keeps a smoothed estimate of queue occupancy and compares it against two programmable thresholds. A low estimate always admits the packet. A high estimate always applies the congestion action. Between the two, a pseudo-random draw applies the action with a probability that rises with the estimate and with the number of packets admitted since the last action. The congestion action is either dropping the arriving packet or admitting it with its ECN bit set, chosen by a control pin. Packets already held in the queue are never touched.

All work happens on the cycle the arrival strobe is high. The averaged occupancy, the arrival time used to measure idle gaps, the packet counter and the random generator change only then. When a packet finds the queue empty, the average is decayed as though one zero-length sample had been seen for every packet transmit slot that passed since the previous arrival. The result is three one-cycle strobes one clock after the arrival. There is no back-pressure: every arrival gets exactly one ruling, and arrivals may come on consecutive cycles. The averaged occupancy is also driven out so the queue manager can read it.

Top module: `rnd_early_drop`

## Requirements
- R1: After reset `avg_o` is 0, all three strobes are low, the packet counter holds the value -1 and the random generator holds 16'hACE1.
- R2: Each cycle with `arr_i` high produces, on the next cycle, exactly one of `enq_o` or `drop_o`. A cycle with `arr_i` low produces no strobe on the next cycle, and the average, counter and random value stay unchanged.
- R3: The average is unsigned fixed point with 8 fraction bits. On an arrival with `qlen_i` nonzero, with k = `wshift_i`, it becomes avg - (avg >> k) + ((qlen_i << 8) >> k).
- R4: On an arrival with `qlen_i` zero, m = (`now_i` - time of the previous arrival) >> `tx_shift_i` using 32-bit wraparound (previous time is 0 after reset), capped at DECAY_MAX (16). The step avg = avg - (avg >> k) is then applied m times. The arrival time is recorded on every arrival.
- R5: When the updated average is below `min_th_i` << 8, the packet is admitted without a mark and the counter becomes -1.
- R6: When the updated average is at or above `max_th_i` << 8, the congestion action is applied and the counter becomes 0.
- R7: Otherwise the counter is incremented (saturating at 32767) to c. With num = `maxp_i` * (avg - (min << 8)) and den = 256 * ((max - min) << 8), the action is applied when c*num >= den, or when r * (den - c*num) < num * 65536. Here r is the current random value, and `maxp_i` is the maximum probability in units of 1/256. After an action the counter becomes 0; otherwise it keeps c.
- R8: The congestion action is `enq_o` and `mark_o` together when `ecn_en_i` is 1, and `drop_o` alone when it is 0. `mark_o` is never high without `enq_o`.
- R9: The random value r is a 16-bit register that steps once per arrival, after use, as r <= {r[14:0], r[15]^r[13]^r[12]^r[10]}. It is never zero.
- R10: The ruling on an arrival uses the average as updated by that same arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_i | input | 1 | Packet arrival strobe, one cycle per packet |
| qlen_i | input | 16 | Queue occupancy in packets, seen at the arrival |
| now_i | input | 32 | Free-running time count |
| min_th_i | input | 16 | Lower average threshold, packets |
| max_th_i | input | 16 | Upper average threshold, packets |
| maxp_i | input | 8 | Maximum probability, units of 1/256 |
| wshift_i | input | 4 | Averaging weight exponent k (weight 2^-k) |
| tx_shift_i | input | 5 | log2 of one packet transmit time in time units |
| ecn_en_i | input | 1 | 1: action marks; 0: action drops |
| enq_o | output | 1 | Admit the packet |
| mark_o | output | 1 | Set the ECN bit of the admitted packet |
| drop_o | output | 1 | Discard the arriving packet |
| avg_o | output | 24 | Averaged occupancy, 16.8 fixed point |

## Verification
The assertions assume that `qlen_i` reports the true occupancy at each arrival and that `now_i` never runs backwards by more than its wrap. They also assume the thresholds, weight and probability stay constant on any cycle that carries an arrival. The rule that the upper region always acts is checked only when `max_th_i` exceeds `min_th_i`. The stimulus changes configuration only in idle gaps, always with min below max. It lets `now_i` count up one per clock, so idle gaps map to known decay step counts, both under and over the cap.

// File: rtl/red_pkg.sv
`timescale 1ns/1ps
package red_pkg;

  typedef enum logic [1:0] {
    ZN_CALM = 2'd0,
    ZN_RAMP = 2'd1,
    ZN_HARD = 2'd2
  } zone_e;

  // Feedback masks of maximal-length Fibonacci generators, shift toward MSB.
  function automatic logic [31:0] lfsr_taps(input int unsigned w);
    case (w)
      8:       return 32'h0000_00B8;
      32:      return 32'h8020_0003;
      default: return 32'h0000_B400;
    endcase
  endfunction

endpackage

// File: rtl/red_lfsr.sv
`timescale 1ns/1ps
module red_lfsr #(
  parameter int LW = 16,
  parameter logic [LW-1:0] SEED = LW'('hACE1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  output logic [LW-1:0] rnd_o
);
  localparam logic [31:0]   TAPS_ALL = red_pkg::lfsr_taps(LW);
  localparam logic [LW-1:0] TAPS     = TAPS_ALL[LW-1:0];

  logic [LW-1:0] st;
  logic          fb;

  assign fb    = ^(st & TAPS);
  assign rnd_o = st;

  always_ff @(posedge clk) begin
    if (!rst_n)      st <= SEED;
    else if (step_i) st <= {st[LW-2:0], fb};
  end

  // R9: generator never locks up in the all-zero state
  a_r9_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    st != '0);
  // R9: the value moves only on arrivals
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(st));
endmodule

// File: rtl/red_avg.sv
`timescale 1ns/1ps
module red_avg #(
  parameter int QW        = 16,
  parameter int FRAC      = 8,
  parameter int TW        = 32,
  parameter int KW        = 4,
  parameter int SHW       = 5,
  parameter int DECAY_MAX = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arr_i,
  input  logic [QW-1:0]        qlen_i,
  input  logic [TW-1:0]        now_i,
  input  logic [KW-1:0]        wshift_i,
  input  logic [SHW-1:0]       tx_shift_i,
  output logic [QW+FRAC-1:0]   avg_q_o,
  output logic [QW+FRAC-1:0]   avg_nxt_o
);
  localparam int AW  = QW + FRAC;
  localparam int STW = $clog2(DECAY_MAX + 1);

  logic [AW-1:0]  avg_r;
  logic [TW-1:0]  t_prev;
  logic [TW-1:0]  elapsed;
  logic [TW-1:0]  slots;
  logic [STW-1:0] steps;
  logic [AW-1:0]  fill;
  logic [AW-1:0]  avg_busy;
  logic [AW-1:0]  chain [DECAY_MAX+1];

  // idle slots since the previous arrival, clipped to the unrolled depth
  assign elapsed = now_i - t_prev;
  assign slots   = elapsed >> tx_shift_i;

  always_comb begin
    if (slots > TW'(DECAY_MAX)) steps = STW'(DECAY_MAX);
    else                        steps = slots[STW-1:0];
  end

  // unrolled decay: each stage removes 2^-k of what is left
  assign chain[0] = avg_r;
  for (genvar g = 0; g < DECAY_MAX; g++) begin : g_decay
    assign chain[g+1] = (STW'(g) < steps) ? chain[g] - (chain[g] >> wshift_i)
                                          : chain[g];
  end

  // occupied queue: shift-and-subtract moving average
  assign fill      = {qlen_i, FRAC'(0)};
  assign avg_busy  = avg_r - (avg_r >> wshift_i) + (fill >> wshift_i);
  assign avg_nxt_o = (qlen_i == '0) ? chain[DECAY_MAX] : avg_busy;
  assign avg_q_o   = avg_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avg_r  <= '0;
      t_prev <= '0;
    end else if (arr_i) begin
      avg_r  <= avg_nxt_o;
      t_prev <= now_i;
    end
  end

  // R2: no arrival, no change to the average
  a_r2_avg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_i |=> $stable(avg_r));
  // R4: an empty-queue arrival can only lower the average
  a_r4_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_i && qlen_i == '0) |=> avg_r <= $past(avg_r));
  // R3: a busy update lands between the old average and the sample
  a_r3_between: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_i && qlen_i != '0) |=>
      (avg_r <= $past(avg_r) || avg_r <= {$past(qlen_i), FRAC'(0)}));
endmodule

// File: rtl/red_decide.sv
`timescale 1ns/1ps
module red_decide
  import red_pkg::*;
#(
  parameter int QW   = 16,
  parameter int FRAC = 8,
  parameter int PW   = 8,
  parameter int RW   = 16,
  parameter int CW   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arr_i,
  input  logic [QW+FRAC-1:0] avg_i,
  input  logic [QW-1:0]      min_th_i,
  input  logic [QW-1:0]      max_th_i,
  input  logic [PW-1:0]      maxp_i,
  input  logic [RW-1:0]      rnd_i,
  output logic               act_o
);
  localparam int AW   = QW + FRAC;
  localparam int NW   = AW + PW;
  localparam int PRW  = NW + CW;
  localparam int CMPW = NW + RW;
  // counter coding: all ones stands for -1, top is the largest positive value
  localparam logic [CW-1:0] CNT_NEG = '1;
  localparam logic [CW-1:0] CNT_TOP = {1'b0, {(CW-1){1'b1}}};

  logic [CW-1:0]   cnt_r;
  logic [CW-1:0]   cnt_inc;
  logic [AW-1:0]   lo_fix, hi_fix, diff, span;
  logic [NW-1:0]   num, den, rest;
  logic [PRW-1:0]  cn;
  logic [CMPW-1:0] lhs, rhs;
  logic            full, hit;
  zone_e           zone;

  assign lo_fix = {min_th_i, FRAC'(0)};
  assign hi_fix = {max_th_i, FRAC'(0)};

  always_comb begin
    if (avg_i < lo_fix)       zone = ZN_CALM;
    else if (avg_i >= hi_fix) zone = ZN_HARD;
    else                      zone = ZN_RAMP;
  end

  assign cnt_inc = (cnt_r == CNT_TOP) ? cnt_r : cnt_r + CW'(1);

  // pb = num/den; pa = num/(den - c*num); compare without a divider
  assign diff = avg_i - lo_fix;
  assign span = hi_fix - lo_fix;
  assign num  = NW'(maxp_i) * NW'(diff);
  assign den  = {span, PW'(0)};
  assign cn   = PRW'(cnt_inc) * PRW'(num);
  assign full = cn >= PRW'(den);
  assign rest = den - cn[NW-1:0];
  assign lhs  = CMPW'(rnd_i) * CMPW'(rest);
  assign rhs  = {num, RW'(0)};
  assign hit  = full || (lhs < rhs);

  always_comb begin
    case (zone)
      ZN_HARD: act_o = 1'b1;
      ZN_RAMP: act_o = hit;
      default: act_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_r <= CNT_NEG;
    end else if (arr_i) begin
      case (zone)
        ZN_CALM: cnt_r <= CNT_NEG;
        ZN_HARD: cnt_r <= '0;
        default: cnt_r <= hit ? '0 : cnt_inc;
      endcase
    end
  end

  // R7: the counter moves only on arrivals
  a_r7_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_i |=> $stable(cnt_r));
  // R7: the only negative value the counter takes is -1
  a_r7_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_r <= CNT_TOP) || (cnt_r == CNT_NEG));
  // R5: a calm arrival always restarts the counter at -1
  a_r5_cnt_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_i && avg_i < lo_fix) |=> cnt_r == CNT_NEG);
endmodule

// File: rtl/rnd_early_drop.sv
`timescale 1ns/1ps
module rnd_early_drop #(
  parameter int QW        = 16,
  parameter int FRAC      = 8,
  parameter int TW        = 32,
  parameter int PW        = 8,
  parameter int RW        = 16,
  parameter int CW        = 16,
  parameter int KW        = 4,
  parameter int SHW       = 5,
  parameter int DECAY_MAX = 16,
  parameter logic [RW-1:0] SEED = RW'('hACE1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arr_i,
  input  logic [QW-1:0]      qlen_i,
  input  logic [TW-1:0]      now_i,
  input  logic [QW-1:0]      min_th_i,
  input  logic [QW-1:0]      max_th_i,
  input  logic [PW-1:0]      maxp_i,
  input  logic [KW-1:0]      wshift_i,
  input  logic [SHW-1:0]     tx_shift_i,
  input  logic               ecn_en_i,
  output logic               enq_o,
  output logic               mark_o,
  output logic               drop_o,
  output logic [QW+FRAC-1:0] avg_o
);
  localparam int AW = QW + FRAC;

  logic [AW-1:0] avg_q, avg_nxt;
  logic [RW-1:0] rnd;
  logic          act;
  logic [AW-1:0] lo_fix, hi_fix;

  red_avg #(
    .QW(QW), .FRAC(FRAC), .TW(TW), .KW(KW), .SHW(SHW), .DECAY_MAX(DECAY_MAX)
  ) u_avg (
    .clk(clk), .rst_n(rst_n), .arr_i(arr_i), .qlen_i(qlen_i), .now_i(now_i),
    .wshift_i(wshift_i), .tx_shift_i(tx_shift_i),
    .avg_q_o(avg_q), .avg_nxt_o(avg_nxt)
  );

  red_lfsr #(.LW(RW), .SEED(SEED)) u_rng (
    .clk(clk), .rst_n(rst_n), .step_i(arr_i), .rnd_o(rnd)
  );

  red_decide #(
    .QW(QW), .FRAC(FRAC), .PW(PW), .RW(RW), .CW(CW)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .arr_i(arr_i), .avg_i(avg_nxt),
    .min_th_i(min_th_i), .max_th_i(max_th_i), .maxp_i(maxp_i),
    .rnd_i(rnd), .act_o(act)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enq_o  <= 1'b0;
      mark_o <= 1'b0;
      drop_o <= 1'b0;
    end else begin
      enq_o  <= arr_i && !(act && !ecn_en_i);
      mark_o <= arr_i && act && ecn_en_i;
      drop_o <= arr_i && act && !ecn_en_i;
    end
  end

  assign avg_o  = avg_q;
  assign lo_fix = {min_th_i, FRAC'(0)};
  assign hi_fix = {max_th_i, FRAC'(0)};

  // R2: one ruling per arrival, one cycle later
  a_r2_one_ruling: assert property (@(posedge clk) disable iff (!rst_n)
    arr_i |=> (enq_o ^ drop_o));
  // R2: silence without an arrival
  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_i |=> !(enq_o || drop_o || mark_o));
  // R8: a mark rides on an admitted packet
  a_r8_mark_with_enq: assert property (@(posedge clk) disable iff (!rst_n)
    mark_o |-> enq_o);
  // R5 R10: updated average below the floor admits unmarked
  a_r5_calm_admits: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_i && avg_nxt < lo_fix) |=> (enq_o && !mark_o));
  // R6 R10: updated average at the ceiling always acts
  a_r6_hard_acts: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_i && max_th_i > min_th_i && avg_nxt >= hi_fix) |=> (drop_o || mark_o));
endmodule

// File: tb/rnd_early_drop_test.sv
`timescale 1ns/1ps
module rnd_early_drop_test;
  localparam int DMAX = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arr_i = 1'b0;
  logic [15:0] qlen_i = '0;
  logic [31:0] now_r = '0;
  logic [15:0] min_th = 16'd4, max_th = 16'd12;
  logic [7:0]  maxp = 8'd64;
  logic [3:0]  wsh = 4'd1;
  logic [4:0]  txs = 5'd3;
  logic        ecn = 1'b0;
  logic        enq_o, mark_o, drop_o;
  logic [23:0] avg_o;

  always #4 clk = ~clk;
  always @(posedge clk) now_r <= now_r + 32'd1;

  rnd_early_drop uut (
    .clk(clk), .rst_n(rst_n), .arr_i(arr_i), .qlen_i(qlen_i), .now_i(now_r),
    .min_th_i(min_th), .max_th_i(max_th), .maxp_i(maxp), .wshift_i(wsh),
    .tx_shift_i(txs), .ecn_en_i(ecn),
    .enq_o(enq_o), .mark_o(mark_o), .drop_o(drop_o), .avg_o(avg_o)
  );

  typedef struct {
    logic enq, mark, drop;
    longint unsigned avg;
    int zone;
    bit qz;
    int unsigned cyc;
  } exp_t;

  exp_t sb[$];
  int total = 0, bad = 0;
  int unsigned cyc = 0;
  bit done = 0;

  // reference state kept from the requirements
  longint unsigned m_avg = 0;
  logic [31:0] m_tprev = '0;
  int m_cnt = -1;
  logic [15:0] m_lfsr = 16'hACE1;

  task automatic arrive(input int q);
    exp_t e;
    longint unsigned a, lo, hi, num, den, cn, r;
    logic [31:0] d32;
    longint unsigned slots;
    int steps, cinc;
    bit hit;
    @(posedge clk); #1;
    if (q == 0) begin
      d32 = now_r - m_tprev;
      slots = longint'(d32 >> txs);
      steps = (slots > DMAX) ? DMAX : int'(slots);
      a = m_avg;
      for (int i = 0; i < steps; i++) a = a - (a >> wsh);
    end else begin
      a = m_avg - (m_avg >> wsh) + ((longint'(q) << 8) >> wsh);
    end
    lo = longint'(min_th) << 8;
    hi = longint'(max_th) << 8;
    if (a < lo) begin
      e.zone = 0; hit = 0; m_cnt = -1;
    end else if (a >= hi) begin
      e.zone = 2; hit = 1; m_cnt = 0;
    end else begin
      e.zone = 1;
      cinc = (m_cnt == 32767) ? m_cnt : m_cnt + 1;
      num = longint'(maxp) * (a - lo);
      den = (hi - lo) << 8;
      cn = longint'(cinc) * num;
      r = longint'(m_lfsr);
      if (cn >= den) hit = 1;
      else hit = (r * (den - cn)) < (num << 16);
      m_cnt = hit ? 0 : cinc;
    end
    e.enq  = !(hit && !ecn);
    e.mark = hit && ecn;
    e.drop = hit && !ecn;
    e.avg  = a;
    e.qz   = (q == 0);
    e.cyc  = cyc;
    m_avg   = a;
    m_tprev = now_r;
    m_lfsr  = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    sb.push_back(e);
    arr_i  = 1'b1;
    qlen_i = 16'(q);
  endtask

  task automatic gap(input int n);
    @(posedge clk); #1;
    arr_i = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  // monitor: pops the item due this cycle and compares
  always @(posedge clk) begin
    exp_t e;
    string tag;
    cyc = cyc + 1;
    #4;
    if (rst_n && !done) begin
      if (sb.size() > 0 && sb[0].cyc == cyc - 1) begin
        e = sb.pop_front();
        tag = (e.zone == 0) ? "R5" : (e.zone == 2) ? "R6 R10" : "R7 R9";
        total++;
        if (enq_o !== e.enq || drop_o !== e.drop) begin
          bad++;
          $display("FAIL %s ruling enq/drop=%b%b expected %b%b", tag,
                   enq_o, drop_o, e.enq, e.drop);
        end
        total++;
        if (mark_o !== e.mark) begin
          bad++;
          $display("FAIL R8 mark=%b expected %b", mark_o, e.mark);
        end
        total++;
        if (longint'(avg_o) != e.avg) begin
          bad++;
          $display("FAIL %s avg=%0d expected %0d", e.qz ? "R4" : "R3",
                   avg_o, e.avg);
        end
      end else if (enq_o || drop_o || mark_o) begin
        total++; bad++;
        $display("FAIL R2 strobe %b%b%b without arrival, expected 000",
                 enq_o, mark_o, drop_o);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #2;
    total++;
    if (avg_o !== 24'd0 || enq_o || mark_o || drop_o) begin
      bad++;
      $display("FAIL R1 reset avg=%0d strobes=%b%b%b expected 0 000",
               avg_o, enq_o, mark_o, drop_o);
    end
    // R5 R3: low occupancy keeps the average under the floor
    for (int i = 0; i < 3; i++) arrive(2);
    gap(2);
    // R7 R9: ramp into the probabilistic band
    for (int i = 0; i < 6; i++) arrive(8);
    // R6 R10: overload drops
    for (int i = 0; i < 6; i++) arrive(30);
    gap(2);
    ecn = 1'b1;
    // R8: overload marks instead
    for (int i = 0; i < 3; i++) arrive(30);
    gap(2);
    ecn = 1'b0;
    // R4: idle decay, below the step cap then above it, then no gap
    gap(40);
    arrive(0);
    gap(400);
    arrive(0);
    arrive(0);
    gap(2);
    // R7: zero probability never acts in the band, full probability does
    maxp = 8'd0; wsh = 4'd3;
    for (int i = 0; i < 30; i++) arrive(8);
    gap(2);
    maxp = 8'd255;
    for (int i = 0; i < 30; i++) arrive(8);
    gap(2);
    // mixed traffic across all regions
    maxp = 8'd40; wsh = 4'd2;
    for (int i = 0; i < 300; i++) begin
      if (i % 5 == 4) begin
        gap(i % 7);
        ecn = ((i / 25) % 2) == 1;
      end
      arrive((i * 7 + 3) % 24);
    end
    gap(4);
    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R2 rulings missing=%0d expected 0", sb.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule